// File: doc/BRIEF.md
# Serial Link Transaction Sequencer

This block drives one complete read or write transaction on a two-wire serial slave link. It sits between a frame encoder, which serialises commands, and a frame receiver, which collects and checks responses. It sends nothing bit by bit itself. On a start request it asks the encoder for the request frame, then asks the receiver for the response. It then acts on the result. A busy slave gets data polls. A damaged response triggers an error poll. A slave that stays busy too long is sent a terminate. A slave that reports a damaged command gets the whole request again after a pause. Every transaction ends with a one-cycle done pulse that carries a status code and, for reads, the returned data.

Between frames the block drives idle clocks on the link itself. Each idle clock is one `clk_tick` cycle, and `sda_level` gives the data line level for that clock. The block also produces the link reset sequence. When external mode is on, the block lets go of the link pins and refuses all work.

Top module: `txn_seq`

## Requirements
- R1: After reset `cmd_valid`, `rx_req`, `clk_tick` and `done` are low, and `pins_drive` is high while `ext_mode` is low. At most one of `cmd_valid`, `rx_req` and `clk_tick` is high in any cycle.
- R2: A response with receive status 0 (good) and tag 0 (acknowledge) ends the transaction with status 0 (ok), and `rd_data` then equals that response's `rx_data`. The command kind for the request is 0, and `cmd_kind` stays stable while `cmd_valid` waits for `cmd_sent`.
- R3: A good response with tag 1 (busy) is followed by exactly DPOLL_CLKS idle clocks at line level 1, then a data poll (command kind 1). This repeats for at most MAX_BUSY polls in one attempt, and DPOLL_CLKS is never fewer than 21.
- R4: On the busy response after MAX_BUSY polls, the block drives DPOLL_CLKS idle clocks and then a terminate (command kind 3). The transaction always ends with status 2 (io_error). `link_lost` is high with done unless the terminate's response is good with tag 0.
- R5: A response with receive status 1 (CRC failure) is followed by EPOLL_CLKS idle clocks and then an error poll (command kind 2). At most CRC_RETRY error polls are sent per attempt. The next CRC failure ends with status 2.
- R6: A good response with tag 3 (command CRC error) is followed by the send-delay clocks, then at least PAUSE_CYC cycles with no idle clocks, then a fresh request (kind 0). Busy and CRC counts restart with each fresh request. After RESEND_MAX resends, a further tag 3 ends with status 2.
- R7: A good response with tag 2 (slave error) ends with status 2 and no further command.
- R8: Receive status 2 (no start bit) ends with status 1 (timeout). Receive status 3 (all-ones frame) ends with status 4 (no_device).
- R9: After every final response, exactly `t_send` idle clocks at level 1 are driven before done. The value 0 gives none.
- R10: A break request drives PRE_CLKS idle clocks at level 1, then BRK_CLKS clocks at level 0, then `t_echo` plus POST_CLKS clocks at level 1. It then signals done with status 0 and `addr_inval` high. `addr_inval` is never high otherwise.
- R11: While `ext_mode` is high, `pins_drive` is low. A start or break accepted from idle gives done with status 3 (busy) on the next cycle, with no command, receive request or idle clock.
- R12: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| brk_req | input | 1 | Begin a break sequence (when idle, start has priority) |
| ext_mode | input | 1 | Link handed to an external controller |
| t_send | input | 8 | Idle clocks after each final response |
| t_echo | input | 8 | Echo-delay clocks used inside the break |
| cmd_valid | output | 1 | Encoder request, held until cmd_sent |
| cmd_kind | output | 2 | 0 request, 1 data poll, 2 error poll, 3 terminate |
| cmd_sent | input | 1 | Encoder has finished the frame |
| rx_req | output | 1 | Receiver request, held until rx_done |
| rx_done | input | 1 | Receiver result valid |
| rx_stat | input | 2 | 0 good, 1 CRC failure, 2 no start bit, 3 all-ones |
| rx_tag | input | 2 | 0 ack, 1 busy, 2 slave error, 3 command CRC error |
| rx_data | input | DW | Response payload |
| clk_tick | output | 1 | One idle link clock this cycle |
| sda_level | output | 1 | Data line level for the idle clock |
| pins_drive | output | 1 | Link pins driven by this block |
| done | output | 1 | Transaction or break complete |
| status | output | 3 | 0 ok, 1 timeout, 2 io_error, 3 busy, 4 no_device |
| rd_data | output | DW | Data of the last acknowledged response |
| link_lost | output | 1 | Terminate not acknowledged (with done) |
| addr_inval | output | 1 | Last-address record must be dropped (with done) |

## Verification
The bench builds the block with MAX_BUSY=3, CRC_RETRY=2, RESEND_MAX=2, EPOLL_CLKS=5, PRE_CLKS=4, BRK_CLKS=8, POST_CLKS=4 and PAUSE_CYC=10. DPOLL_CLKS stays at 21. With these small limits, a random response script of a few dozen entries can run out the busy, CRC and resend budgets in one transaction, as well as mixtures of them. Every idle-clock run, command kind and final status is compared with an independent model of the retry rules.

// File: rtl/txn_seq.sv
module txn_seq #(
  parameter int MAX_BUSY   = 200,
  parameter int CRC_RETRY  = 10,
  parameter int RESEND_MAX = 10,
  parameter int DPOLL_CLKS = 21,
  parameter int EPOLL_CLKS = 50,
  parameter int PRE_CLKS   = 16,
  parameter int BRK_CLKS   = 256,
  parameter int POST_CLKS  = 16,
  parameter int PAUSE_CYC  = 1000,
  parameter int DW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          brk_req,
  input  logic          ext_mode,
  input  logic [7:0]    t_send,
  input  logic [7:0]    t_echo,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  input  logic          cmd_sent,
  output logic          rx_req,
  input  logic          rx_done,
  input  logic [1:0]    rx_stat,
  input  logic [1:0]    rx_tag,
  input  logic [DW-1:0] rx_data,
  output logic          clk_tick,
  output logic          sda_level,
  output logic          pins_drive,
  output logic          done,
  output logic [2:0]    status,
  output logic [DW-1:0] rd_data,
  output logic          link_lost,
  output logic          addr_inval
);
  localparam int SUMC = EPOLL_CLKS + DPOLL_CLKS + PRE_CLKS + POST_CLKS + 255;
  localparam int M1   = (BRK_CLKS > PAUSE_CYC) ? BRK_CLKS : PAUSE_CYC;
  localparam int MAXC = (M1 > SUMC) ? M1 : SUMC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(MAX_BUSY + 2);
  localparam int RW   = $clog2(CRC_RETRY + 2);
  localparam int SW   = $clog2(RESEND_MAX + 2);

  localparam logic [2:0] ST_OK = 3'd0, ST_TMO = 3'd1, ST_IO = 3'd2, ST_BUSY = 3'd3, ST_NODEV = 3'd4;
  localparam logic [1:0] K_REQ = 2'd0, K_DPOLL = 2'd1, K_EPOLL = 2'd2, K_TERM = 2'd3;
  localparam logic [1:0] RX_GOOD = 2'd0, RX_CRC = 2'd1, RX_TMO = 2'd2;
  localparam logic [1:0] T_ACK = 2'd0, T_BUSY = 2'd1, T_ERRA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RX, S_BURST, S_PAUSE, S_DONE} st_t;
  typedef enum logic [1:0] {A_CMD, A_FIN, A_BRK} act_t;

  st_t           st;
  act_t          aft;
  logic [CW-1:0] cnt;
  logic          lvl_low, term_f, errc_f, brk_f, lost_r;
  logic [1:0]    kind, ph;
  logic [BW-1:0] busy_n;
  logic [RW-1:0] crc_n;
  logic [SW-1:0] rs_n;
  logic [2:0]    fin;
  logic [DW-1:0] rd_q;
  logic          in_idle;

  assign in_idle    = (st == S_IDLE);
  assign cmd_valid  = (st == S_CMD);
  assign cmd_kind   = kind;
  assign rx_req     = (st == S_RX);
  assign clk_tick   = (st == S_BURST) && (cnt != '0);
  assign sda_level  = ~lvl_low;
  assign pins_drive = ~ext_mode;
  assign done       = (st == S_DONE);
  assign status     = fin;
  assign rd_data    = rd_q;
  assign link_lost  = done && lost_r;
  assign addr_inval = done && brk_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  aft <= A_FIN;  cnt <= '0;  lvl_low <= 1'b0;
      term_f <= 1'b0;  errc_f <= 1'b0;  brk_f <= 1'b0;  lost_r <= 1'b0;
      kind <= K_REQ;  ph <= 2'd0;  busy_n <= '0;  crc_n <= '0;  rs_n <= '0;
      fin <= ST_OK;  rd_q <= '0;
    end else if (in_idle) begin
      if (start || brk_req) begin
        lost_r <= 1'b0;  term_f <= 1'b0;  errc_f <= 1'b0;  brk_f <= 1'b0;
        busy_n <= '0;  crc_n <= '0;  rs_n <= '0;
        if (ext_mode) begin
          fin <= ST_BUSY;  st <= S_DONE;
        end else if (start) begin
          fin <= ST_OK;  kind <= K_REQ;  st <= S_CMD;
        end else begin
          brk_f <= 1'b1;  ph <= 2'd0;  fin <= ST_OK;
          cnt <= CW'(PRE_CLKS);  lvl_low <= 1'b0;  aft <= A_BRK;  st <= S_BURST;
        end
      end
    end else begin
      case (st)
        S_CMD: if (cmd_sent) st <= S_RX;
        S_RX: if (rx_done) begin
          st <= S_BURST;  lvl_low <= 1'b0;  aft <= A_FIN;  cnt <= CW'(t_send);
          if (term_f) begin
            fin    <= ST_IO;
            lost_r <= !(rx_stat == RX_GOOD && rx_tag == T_ACK);
          end else begin
            case (rx_stat)
              RX_TMO: fin <= ST_TMO;
              RX_CRC:
                if (crc_n < RW'(CRC_RETRY)) begin
                  crc_n <= crc_n + 1'b1;  kind <= K_EPOLL;
                  cnt <= CW'(EPOLL_CLKS);  aft <= A_CMD;
                end else fin <= ST_IO;
              RX_GOOD:
                case (rx_tag)
                  T_ACK: begin fin <= ST_OK; rd_q <= rx_data; end
                  T_BUSY: begin
                    cnt <= CW'(DPOLL_CLKS);  aft <= A_CMD;
                    if (busy_n < BW'(MAX_BUSY)) begin
                      busy_n <= busy_n + 1'b1;  kind <= K_DPOLL;
                    end else begin
                      term_f <= 1'b1;  kind <= K_TERM;
                    end
                  end
                  T_ERRA: fin <= ST_IO;
                  default: begin fin <= ST_IO; errc_f <= 1'b1; end
                endcase
              default: fin <= ST_NODEV;
            endcase
          end
        end
        S_BURST:
          if (cnt <= CW'(1)) begin
            case (aft)
              A_CMD: st <= S_CMD;
              A_FIN:
                if (errc_f && rs_n < SW'(RESEND_MAX)) begin
                  rs_n <= rs_n + 1'b1;  errc_f <= 1'b0;
                  busy_n <= '0;  crc_n <= '0;
                  cnt <= CW'(PAUSE_CYC);  st <= S_PAUSE;
                end else st <= S_DONE;
              default:
                case (ph)
                  2'd0: begin ph <= 2'd1; cnt <= CW'(BRK_CLKS);  lvl_low <= 1'b1; end
                  2'd1: begin ph <= 2'd2; cnt <= CW'(t_echo);    lvl_low <= 1'b0; end
                  2'd2: begin ph <= 2'd3; cnt <= CW'(POST_CLKS); end
                  default: st <= S_DONE;
                endcase
            endcase
          end else cnt <= cnt - 1'b1;
        S_PAUSE:
          if (cnt <= CW'(1)) begin
            kind <= K_REQ;  st <= S_CMD;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txn_seq_chk #(
  parameter int DPOLL_CLKS = 21
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       brk_req,
  input logic       ext_mode,
  input logic       in_idle,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind,
  input logic       cmd_sent,
  input logic       rx_req,
  input logic       clk_tick,
  input logic       done,
  input logic [2:0] status,
  input logic       link_lost,
  input logic       addr_inval
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (rx_req) run <= '0;
    else if (clk_tick && run != 16'hFFFF) run <= run + 1'b1;
  end

  initial AST_DPOLL_FLOOR: assert (DPOLL_CLKS >= 21); // R3

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_tick && (cmd_valid || rx_req)) && !(cmd_valid && rx_req)); // R1
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_sent |=> cmd_valid && $stable(cmd_kind)); // R2
  AST_DPOLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && cmd_kind == 2'd1 |-> int'(run) >= DPOLL_CLKS); // R3
  AST_LOST_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |-> done && status == 3'd2); // R4
  AST_INVAL_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inval |-> done && status == 3'd0); // R10
  AST_EXT_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && ext_mode && (start || brk_req) |=> done && status == 3'd3); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
endmodule

bind txn_seq txn_seq_chk #(.DPOLL_CLKS(DPOLL_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .brk_req(brk_req), .ext_mode(ext_mode),
  .in_idle(in_idle), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_sent(cmd_sent),
  .rx_req(rx_req), .clk_tick(clk_tick), .done(done), .status(status),
  .link_lost(link_lost), .addr_inval(addr_inval)
);

// File: tb/sim_txn_seq.sv
module sim_txn_seq;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 3, CR = 2, RM = 2, DP = 21, EP = 5, PRE = 4, BRK = 8, POST = 4, PAU = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, brk_req = 1'b0, ext_mode = 1'b0;
  logic [7:0] t_send = 8'd0, t_echo = 8'd0;
  logic cmd_valid, cmd_sent, rx_req, rx_done;
  logic [1:0] cmd_kind, rx_stat, rx_tag;
  logic [31:0] rx_data, rd_data;
  logic clk_tick, sda_level, pins_drive, done, link_lost, addr_inval;
  logic [2:0] status;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_seq #(.MAX_BUSY(MB), .CRC_RETRY(CR), .RESEND_MAX(RM), .DPOLL_CLKS(DP),
            .EPOLL_CLKS(EP), .PRE_CLKS(PRE), .BRK_CLKS(BRK), .POST_CLKS(POST),
            .PAUSE_CYC(PAU), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .brk_req(brk_req), .ext_mode(ext_mode),
    .t_send(t_send), .t_echo(t_echo), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_sent(cmd_sent), .rx_req(rx_req), .rx_done(rx_done), .rx_stat(rx_stat),
    .rx_tag(rx_tag), .rx_data(rx_data), .clk_tick(clk_tick), .sda_level(sda_level),
    .pins_drive(pins_drive), .done(done), .status(status), .rd_data(rd_data),
    .link_lost(link_lost), .addr_inval(addr_inval));

  int n_chk = 0, n_bad = 0;
  int rs[0:63], rt[0:63];
  logic [31:0] rdv[0:63];
  int ri = 0, cyc = 0, last_tick = 0, min_gap = 0;
  bit seen_tick = 0;
  int ev_t[0:255], ev_n[0:255], ev_len = 0;
  int xv_t[0:255], xv_n[0:255], xv_len = 0;
  int x_stat, x_used;
  bit x_lost, x_inval;
  logic [31:0] x_data;
  int g_stat;
  bit g_lost, g_inval;
  logic [31:0] g_data;

  function automatic void add_ev(bit is_ref, int t, int n);
    if (n == 0) return;
    if (is_ref) begin
      if (xv_len > 0 && t >= 4 && xv_t[xv_len-1] == t) xv_n[xv_len-1] += n;
      else if (xv_len < 256) begin xv_t[xv_len] = t; xv_n[xv_len] = n; xv_len++; end
    end else begin
      if (ev_len > 0 && t >= 4 && ev_t[ev_len-1] == t) ev_n[ev_len-1] += n;
      else if (ev_len < 256) begin ev_t[ev_len] = t; ev_n[ev_len] = n; ev_len++; end
    end
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cmd_sent <= 1'b0; rx_done <= 1'b0; rx_stat <= 2'd0; rx_tag <= 2'd0; rx_data <= '0;
    end else begin
      cmd_sent <= 1'b0; rx_done <= 1'b0;
      if (clk_tick) begin add_ev(0, sda_level ? 4 : 5, 1); last_tick = cyc; seen_tick = 1; end
      if (cmd_valid && !cmd_sent) begin
        add_ev(0, int'(cmd_kind), 1);
        if (cmd_kind == 2'd0 && seen_tick && (cyc - last_tick) < min_gap) min_gap = cyc - last_tick;
        cmd_sent <= 1'b1;
      end
      if (rx_req && !rx_done) begin
        rx_stat <= 2'(rs[ri]); rx_tag <= 2'(rt[ri]); rx_data <= rdv[ri];
        if (ri < 63) ri++;
        rx_done <= 1'b1;
      end
    end
  end

  // Reference of the retry rules, independent of the RTL structure
  task automatic ref_txn(input int ts);
    int i = 0, busy = 0, crc = 0, rsn = 0;
    bit term = 0, fin = 0;
    xv_len = 0; x_lost = 0; x_inval = 0; x_data = 'x;
    add_ev(1, 0, 1);
    while (!fin && i < 64) begin
      int s = rs[i], t = rt[i];
      i++;
      if (term) begin
        x_lost = !(s == 0 && t == 0); x_stat = 2; add_ev(1, 4, ts); fin = 1;
      end else if (s == 2) begin x_stat = 1; add_ev(1, 4, ts); fin = 1; end
      else if (s == 3) begin x_stat = 4; add_ev(1, 4, ts); fin = 1; end
      else if (s == 1) begin
        if (crc < CR) begin crc++; add_ev(1, 4, EP); add_ev(1, 2, 1); end
        else begin x_stat = 2; add_ev(1, 4, ts); fin = 1; end
      end else if (t == 0) begin x_stat = 0; x_data = rdv[i-1]; add_ev(1, 4, ts); fin = 1; end
      else if (t == 1) begin
        add_ev(1, 4, DP);
        if (busy < MB) begin busy++; add_ev(1, 1, 1); end
        else begin term = 1; add_ev(1, 3, 1); end
      end else if (t == 2) begin x_stat = 2; add_ev(1, 4, ts); fin = 1; end
      else begin
        add_ev(1, 4, ts);
        if (rsn < RM) begin rsn++; busy = 0; crc = 0; add_ev(1, 0, 1); end
        else begin x_stat = 2; fin = 1; end
      end
    end
    x_used = i;
  endtask

  task automatic clear_obs();
    ev_len = 0; ri = 0; seen_tick = 0; min_gap = 1000000;
  endtask

  task automatic wait_done(input string rq);
    int k = 0;
    while (done !== 1'b1 && k < 6000) begin @(negedge clk); k++; end
    check(k < 6000, rq, "done reached", k, 6000);
    g_stat = int'(status); g_lost = link_lost; g_inval = addr_inval; g_data = rd_data;
    @(negedge clk);
    check(done == 1'b0, "R12", "done single cycle", int'(done), 0);
  endtask

  task automatic cmp_events(input string rq);
    bit ok = (ev_len == xv_len);
    int at = -1;
    for (int j = 0; j < xv_len && j < ev_len; j++)
      if (ok && (ev_t[j] != xv_t[j] || ev_n[j] != xv_n[j])) begin ok = 0; at = j; end
    if (at >= 0) check(0, rq, "event type*1000+count", ev_t[at]*1000 + ev_n[at], xv_t[at]*1000 + xv_n[at]);
    else check(ok, rq, "event count", ev_len, xv_len);
  endtask

  task automatic run_txn(input string rq, input int ts);
    t_send = 8'(ts);
    clear_obs();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(rq);
    ref_txn(ts);
    check(g_stat == x_stat, rq, "status", g_stat, x_stat);
    check(g_lost == x_lost, rq, "link_lost", int'(g_lost), int'(x_lost));
    check(g_inval == 1'b0, "R10", "addr_inval outside break", int'(g_inval), 0);
    check(ri == x_used, rq, "responses used", ri, x_used);
    cmp_events(rq);
    if (x_stat == 0) check(g_data == x_data, rq, "rd_data", int'(g_data), int'(x_data));
  endtask

  task automatic set_rsp(input int k, input int s, input int t);
    rs[k] = s; rt[k] = t; rdv[k] = 32'hA5000000 + 32'(k * 7 + s * 3 + t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int k = 0; k < 64; k++) set_rsp(k, 0, 0);
    repeat (3) @(negedge clk);
    check(!cmd_valid && !rx_req && !clk_tick && !done, "R1", "idle after reset",
          int'({cmd_valid, rx_req, clk_tick, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && !rx_req && !clk_tick && !done, "R1", "idle after release",
          int'({cmd_valid, rx_req, clk_tick, done}), 0);
    check(pins_drive == 1'b1, "R1", "pins driven", int'(pins_drive), 1);

    set_rsp(0, 0, 0); run_txn("R2", 3);
    set_rsp(0, 0, 1); set_rsp(1, 0, 1); set_rsp(2, 0, 0); run_txn("R3", 2);
    for (int k = 0; k < 4; k++) set_rsp(k, 0, 1);
    set_rsp(4, 0, 0); run_txn("R4", 1);
    for (int k = 0; k < 4; k++) set_rsp(k, 0, 1);
    set_rsp(4, 0, 2); run_txn("R4", 1);
    check(g_lost == 1'b1, "R4", "lost on refused terminate", int'(g_lost), 1);
    set_rsp(0, 1, 0); set_rsp(1, 1, 0); set_rsp(2, 0, 0); run_txn("R5", 2);
    set_rsp(0, 1, 0); set_rsp(1, 1, 0); set_rsp(2, 1, 0); run_txn("R5", 2);
    set_rsp(0, 0, 3); set_rsp(1, 0, 1); set_rsp(2, 0, 3); set_rsp(3, 0, 0); run_txn("R6", 2);
    check(min_gap >= PAU, "R6", "pause before resend", min_gap, PAU);
    set_rsp(0, 0, 3); set_rsp(1, 0, 3); set_rsp(2, 0, 3); run_txn("R6", 0);
    set_rsp(0, 0, 2); run_txn("R7", 2);
    set_rsp(0, 2, 0); run_txn("R8", 1);
    set_rsp(0, 3, 0); run_txn("R8", 1);
    set_rsp(0, 0, 0); run_txn("R9", 0);

    t_echo = 8'd5; clear_obs();
    @(negedge clk) brk_req = 1'b1;
    @(negedge clk) brk_req = 1'b0;
    wait_done("R10");
    xv_len = 0;
    add_ev(1, 4, PRE); add_ev(1, 5, BRK); add_ev(1, 4, 5); add_ev(1, 4, POST);
    cmp_events("R10");
    check(g_stat == 0, "R10", "break status", g_stat, 0);
    check(g_inval == 1'b1, "R10", "addr_inval", int'(g_inval), 1);

    @(negedge clk) ext_mode = 1'b1;
    #1 check(pins_drive == 1'b0, "R11", "pins released", int'(pins_drive), 0);
    for (int m = 0; m < 2; m++) begin
      clear_obs();
      @(negedge clk) begin start = (m == 0); brk_req = (m == 1); end
      @(negedge clk) begin start = 1'b0; brk_req = 1'b0; end
      check(done == 1'b1, "R11", "refusal next cycle", int'(done), 1);
      wait_done("R11");
      check(g_stat == 3, "R11", "busy status", g_stat, 3);
      check(ev_len == 0 && ri == 0, "R11", "no link activity", ev_len + ri, 0);
      check(g_inval == 1'b0, "R11", "no addr_inval", int'(g_inval), 0);
    end
    @(negedge clk) ext_mode = 1'b0;

    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 64; k++) begin
        int p = int'($urandom_range(99));
        set_rsp(k, p < 70 ? 0 : p < 85 ? 1 : p < 93 ? 2 : 3, int'($urandom_range(3)));
      end
      run_txn("R2-mix", int'($urandom_range(7)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule